// File: doc/BRIEF.md
# Banked Register File with Write-Bank Conflict Rejection

This block holds the architectural or physical register values of a four-wide datapath. Its storage is split into banks, and each bank has a small number of write ports. Up to one write-back request arrives per issue slot in every cycle. When more requests map to one bank than that bank can take, the block commits the writes that win arbitration. It flags the rest in the same cycle so that the pipeline can replay their instructions. There is no write buffer and the block never stalls.

The bank of a register is given by the low bits of its number; the remaining upper bits select the row inside the bank. On the read side, every bank has its own read ports, each addressed by a row number. A read arbiter outside this block routes operand addresses onto these ports. Reads are combinational and see the contents as they were before the current clock edge.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register reads as zero on every read port.
- R2: Register number n lives in bank n mod NBANK (the low log2(NBANK) bits of n) at row n / NBANK (the upper bits). Read port p of bank b with row r returns register r*NBANK+b.
- R3: A write that is enabled and not rejected stores its data at the rising clock edge. A read in the same cycle returns the previous value.
- R4: When NWP or fewer enabled writes in a cycle map to one bank, none of them is rejected.
- R5: When more than NWP enabled writes map to one bank, the NWP lowest-numbered slots among them are accepted. Every higher one has its bit of wr_reject driven high in that same cycle. Slot k of wr_reject is bit k.
- R6: A rejected write leaves the target register unchanged.
- R7: wr_reject is never high for a slot whose wr_en is low, and a disabled slot takes no write port.
- R8: Writes that map to pairwise distinct banks are all accepted, whatever the number of enabled slots.
- R9: The read ports of a bank are independent; two ports given the same row return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears all registers |
| wr_en | input | NSLOT (4) | Per-slot write request |
| wr_addr | input | NSLOT*log2(NREG) (24) | Per-slot register number, slot k at bits [k*6 +: 6] |
| wr_data | input | NSLOT*W (128) | Per-slot write data, slot k at bits [k*32 +: 32] |
| wr_reject | output | NSLOT (4) | Per-slot conflict flag, same cycle as the request |
| rd_row | input | NBANK*NRP*log2(NREG/NBANK) (48) | Row for read port p of bank b at index b*NRP+p |
| rd_data | output | NBANK*NRP*W (512) | Data for read port p of bank b at index b*NRP+p |

## Verification
The bench builds the block with its defaults: 64 registers of 32 bits in 8 banks, 2 read and 2 write ports per bank, and 4 slots. Because 4 slots exceed the 2 write ports of a bank, three-way and four-way pile-ups on one bank can occur. Those pile-ups show the slot-order priority and the state left behind by rejected writes. Eight banks also give room for four writes to four different banks, and for every mix in between. Random traffic is drawn over a small address range so that conflicts happen often.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int NREG  = 64,
  parameter int W     = 32,
  parameter int NBANK = 8,
  parameter int NRP   = 2,
  parameter int NWP   = 2,
  parameter int NSLOT = 4,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = $clog2(NBANK),
  localparam int RW   = AW - BW,
  localparam int NPRT = NBANK * NRP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSLOT-1:0]    wr_en,
  input  logic [NSLOT*AW-1:0] wr_addr,
  input  logic [NSLOT*W-1:0]  wr_data,
  output logic [NSLOT-1:0]    wr_reject,
  input  logic [NPRT*RW-1:0]  rd_row,
  output logic [NPRT*W-1:0]   rd_data
);

  logic [W-1:0] mem [NREG];

  always_comb begin
    int ahead;
    for (int s = 0; s < NSLOT; s++) begin
      ahead = 0;
      for (int t = 0; t < s; t++)
        if (wr_en[t] && wr_addr[t*AW +: BW] == wr_addr[s*AW +: BW]) ahead++;
      wr_reject[s] = wr_en[s] && (ahead >= NWP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++)
        if (wr_en[s] && !wr_reject[s])
          mem[wr_addr[s*AW +: AW]] <= wr_data[s*W +: W];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar p = 0; p < NRP; p++) begin : g_port
      localparam int IDX = b * NRP + p;
      assign rd_data[IDX*W +: W] = mem[{rd_row[IDX*RW +: RW], BW'(b)}];
    end
  end

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int NREG  = 64,
  parameter int W     = 32,
  parameter int NBANK = 8,
  parameter int NWP   = 2,
  parameter int NSLOT = 4,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = $clog2(NBANK)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NSLOT-1:0]    wr_en,
  input logic [NSLOT*AW-1:0] wr_addr,
  input logic [NSLOT*W-1:0]  wr_data,
  input logic [NSLOT-1:0]    wr_reject,
  input logic [W-1:0]        mem [NREG]
);

  logic [NSLOT-1:0] acc_m [NBANK];
  logic [NSLOT-1:0] rej_m [NBANK];

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      for (int s = 0; s < NSLOT; s++) begin
        acc_m[b][s] = wr_en[s] && !wr_reject[s] && wr_addr[s*AW +: BW] == BW'(b);
        rej_m[b][s] = wr_reject[s] && wr_addr[s*AW +: BW] == BW'(b);
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    p_rej_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject[s] |-> wr_en[s]);
    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[s] && !wr_reject[s]) |=>
        mem[$past(wr_addr[s*AW +: AW])] == $past(wr_data[s*W +: W]));
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject[s] |=>
        mem[$past(wr_addr[s*AW +: AW])] == $past(mem[wr_addr[s*AW +: AW]]));
    if (s < NWP) begin : g_low
      p_low_slot_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reject[s]);
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bk
    p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(acc_m[b]) <= NWP);
    p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rej_m[b] != '0) |-> ($countones(acc_m[b]) == NWP));
  end

endmodule

bind banked_regfile banked_regfile_chk #(
  .NREG(NREG), .W(W), .NBANK(NBANK), .NWP(NWP), .NSLOT(NSLOT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_reject(wr_reject), .mem(mem)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;
  localparam int NREG = 64, W = 32, NBANK = 8, NRP = 2, NWP = 2, NSLOT = 4;
  localparam int AW = 6, BW = 3, RW = 3, NPRT = NBANK * NRP;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n;
  logic [NSLOT-1:0]    we;
  logic [NSLOT*AW-1:0] wa;
  logic [NSLOT*W-1:0]  wd;
  logic [NSLOT-1:0]    rej;
  logic [NPRT*RW-1:0]  rr;
  logic [NPRT*W-1:0]   rd;

  logic [W-1:0] model [NREG];
  int checks = 0, errors = 0;

  banked_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .wr_reject(rej), .rd_row(rr), .rd_data(rd)
  );

  function automatic logic [NSLOT-1:0] exp_rej(logic [NSLOT-1:0] e, logic [NSLOT*AW-1:0] a);
    logic [NSLOT-1:0] r;
    for (int s = 0; s < NSLOT; s++) begin
      int c = 0;
      for (int t = 0; t < s; t++)
        if (e[t] && a[t*AW +: BW] == a[s*AW +: BW]) c++;
      r[s] = e[s] && c >= NWP;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int row = 0; row < NREG / NBANK; row++) begin
      for (int i = 0; i < NPRT; i++) rr[i*RW +: RW] = RW'(row);
      #1;
      for (int b = 0; b < NBANK; b++)
        for (int p = 0; p < NRP; p++)
          chk(req, rd[(b*NRP+p)*W +: W], model[row*NBANK+b]);
    end
  endtask

  task automatic do_write(input logic [NSLOT-1:0] e, input logic [NSLOT*AW-1:0] a,
                          input logic [NSLOT*W-1:0] d, input string req);
    logic [NSLOT-1:0] er;
    @(negedge clk);
    we = e; wa = a; wd = d;
    er = exp_rej(e, a);
    for (int s = 0; s < NSLOT; s++) begin
      int rg = int'(a[s*AW +: AW]);
      rr[((rg % NBANK)*NRP)*RW +: RW] = RW'(rg / NBANK);
      #1;
      chk("R3 same-cycle read old", rd[((rg % NBANK)*NRP)*W +: W], model[rg]);
    end
    #1;
    chk(req, 32'(rej), 32'(er));
    @(posedge clk);
    for (int s = 0; s < NSLOT; s++)
      if (e[s] && !er[s]) model[a[s*AW +: AW]] = d[s*W +: W];
    @(negedge clk);
    we = '0;
  endtask

  function automatic logic [NSLOT*AW-1:0] pack4(int a0, int a1, int a2, int a3);
    return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
  endfunction

  bit done = 0;

  initial begin
    logic [NSLOT*AW-1:0] a;
    logic [NSLOT*W-1:0]  d;
    logic [NSLOT-1:0]    e;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    rst_n = 1'b0; we = '0; wa = '0; wd = '0; rr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset zero");

    do_write(4'b0001, pack4(9, 0, 0, 0), {32'h0, 32'h0, 32'h0, 32'hA5A5_0009}, "R3 single write reject");
    check_all("R2 bank/row mapping and R3 commit");

    do_write(4'b1111, pack4(0, 8, 16, 24),
             {32'hD000_0024, 32'hC000_0016, 32'hB000_0008, 32'hA000_0000}, "R5 four to one bank");
    check_all("R6 rejected writes keep contents");

    do_write(4'b1110, pack4(3, 11, 19, 27),
             {32'h3333_0027, 32'h2222_0019, 32'h1111_0011, 32'h0}, "R5 three to one bank, slot0 off");
    check_all("R6 after three-way conflict");

    do_write(4'b1010, pack4(2, 10, 18, 26),
             {32'h4444_0026, 32'h0, 32'h5555_0010, 32'h0}, "R4 two to one bank");
    do_write(4'b0000, pack4(4, 12, 20, 28), {4{32'hFFFF_FFFF}}, "R7 all disabled");
    do_write(4'b0110, pack4(5, 13, 21, 29),
             {32'h0, 32'h6666_0021, 32'h7777_0013, 32'h0}, "R7 disabled slots take no port");
    check_all("R7 disabled writes leave contents");

    do_write(4'b1111, pack4(1, 12, 23, 30),
             {32'h8888_0030, 32'h9999_0023, 32'hAAAA_0012, 32'hBBBB_0001}, "R8 four distinct banks");
    check_all("R8 all four committed");

    for (int i = 0; i < NPRT; i++) rr[i*RW +: RW] = RW'(i % 8);
    rr[(1*NRP+0)*RW +: RW] = 3'd1;
    rr[(1*NRP+1)*RW +: RW] = 3'd1;
    rr[(0*NRP+0)*RW +: RW] = 3'd3;
    rr[(0*NRP+1)*RW +: RW] = 3'd1;
    #1;
    chk("R9 same row both ports", rd[(1*NRP+1)*W +: W], rd[(1*NRP+0)*W +: W]);
    chk("R9 port independent p0", rd[(0*NRP+0)*W +: W], model[24]);
    chk("R9 port independent p1", rd[(0*NRP+1)*W +: W], model[8]);

    for (int it = 0; it < 400; it++) begin
      e = 4'($urandom);
      for (int s = 0; s < NSLOT; s++) begin
        bit dup;
        do begin
          a[s*AW +: AW] = AW'($urandom_range(0, 31));
          dup = 0;
          for (int t = 0; t < s; t++)
            if (a[t*AW +: AW] == a[s*AW +: AW]) dup = 1;
        end while (dup);
        d[s*W +: W] = $urandom;
      end
      do_write(e, a, d, "R5 random reject pattern");
      if (it % 50 == 49) check_all("R6 random contents");
    end
    check_all("R3 final contents");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule